// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit cipher key. It uses one round datapath, one round per clock. That datapath holds sixteen byte substitutions, a fixed row rotation, a column mix in GF(2^8) and a round-key XOR. A small expansion stage beside the datapath derives each round key from the previous one in the same cycle that the key is used, so no expanded key table is stored. The last round bypasses the column mix.

Plaintext and key enter together over a valid/ready input. A block is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` stays low for the whole run of a block. While it is low, `in_valid` and the input buses have no effect, and a source that wants to keep its data must hold it until `in_ready` returns. The output has no back-pressure. `out_valid` is a one-cycle strobe, and `out_block` keeps the ciphertext until the next block is accepted. A consumer that cannot take the result in the strobe cycle can still read `out_block` later, while the core stays idle.

Byte i of a 128-bit bus sits at bits [127-8i -: 8], so byte 0 is the most significant. The state is filled column by column: bytes 0..3 form column 0, bytes 4..7 form column 1, and so on.

Top module: `aes128_iter_core`

## Requirements
- R1: On a synchronous active-high `rst`, the next cycle shows `in_ready` high and `out_valid` low. This also holds when a block is in progress, and that block then never produces a strobe.
- R2: `in_ready` is high exactly when the core is idle. A block is accepted on an edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle after that edge.
- R3: Count the accepting edge as the first. `out_valid` is high in the cycle after the 11th rising edge: one edge for the initial key XOR and one for each of the 10 rounds.
- R4: `out_valid` is high for a single cycle per accepted block and ignores any consumer state.
- R5: `in_valid` and the input buses have no effect while `in_ready` is low. The result of the running block and its timing stay unchanged.
- R6: Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a.
- R7: The ciphertext equals standard AES-128 encryption of `in_block` under `in_key`. Byte i is at bits [127-8i -: 8], and the state is filled column-major.
- R8: The byte substitution is the standard AES S-box, which maps 0x95 to 0x2A and 0x00 to 0x63. An all-zero key and block give 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R9: While idle with no new block accepted, `out_block` keeps the last ciphertext.
- R10: In the strobe cycle `in_ready` is already high, so a new block can be accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Plaintext and key are offered |
| in_ready | output | 1 | Core idle, offer will be taken |
| in_key | input | 128 | Cipher key, byte 0 in the top bits |
| in_block | input | 128 | Plaintext, byte 0 in the top bits |
| out_valid | output | 1 | One-cycle strobe: ciphertext is ready |
| out_block | output | 128 | Ciphertext, held until the next acceptance |

## Verification
The bench builds the core with its package defaults: 128-bit blocks, 32-bit words and 10 rounds. Every run therefore goes through the final round without the column mix, and the round constant wraps past 0x80 to 0x1B and 0x36. These paths only show up in a full-length key schedule. A behavioural reference model predicts `in_ready`, `out_valid` and `out_block` on every cycle. The stimulus covers two known answers, random blocks with input noise during busy runs, a back-to-back acceptance in the strobe cycle, and a reset that cuts a block off mid-run.

// File: rtl/aes_ip_pkg.sv
package aes_ip_pkg;
  localparam int BYTE_W     = 8;
  localparam int BLK_W      = 128;
  localparam int WORD_W     = 32;
  localparam int NB         = BLK_W / BYTE_W;
  localparam int NCOL       = BLK_W / WORD_W;
  localparam int NROW       = WORD_W / BYTE_W;
  localparam int NUM_ROUNDS = 10;
  localparam int LATENCY    = NUM_ROUNDS + 1;
  localparam int RND_W      = $clog2(NUM_ROUNDS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t RCON_FIRST = 8'h01;
  localparam byte_t AFFINE_C   = 8'h63;
  localparam byte_t REDUCE     = 8'h1b;

  function automatic byte_t xtime(byte_t v);
    return {v[BYTE_W-2:0], 1'b0} ^ (v[BYTE_W-1] ? REDUCE : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t p = '0;
    byte_t x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ x;
      x = xtime(x);
    end
    return p;
  endfunction

  function automatic byte_t rotl(byte_t v, int n);
    logic [2*BYTE_W-1:0] d;
    d = {v, v} << n;
    return d[2*BYTE_W-1:BYTE_W];
  endfunction

  // multiplicative inverse as v^254, then the affine map
  function automatic byte_t sbox_fn(byte_t v);
    byte_t sq  = v;
    byte_t inv = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ AFFINE_C;
  endfunction
endpackage

// File: rtl/aes_sbox_lane.sv
module aes_sbox_lane
  import aes_ip_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*BYTE_W-1:0] din,
  output logic [LANES*BYTE_W-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*BYTE_W +: BYTE_W] = sbox_fn(din[i*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/aes_round_xform.sv
module aes_round_xform
  import aes_ip_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  logic [BLK_W-1:0] subst;
  logic [BLK_W-1:0] shifted;
  logic [BLK_W-1:0] mixed;

  aes_sbox_lane #(.LANES(NB)) u_sub (
    .din  (state_i),
    .dout (subst)
  );

  // byte (r,c) takes the byte from column (c+r) mod NCOL of the same row
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      localparam int DST = NROW * c + r;
      localparam int SRC = NROW * ((c + r) % NCOL) + r;
      assign shifted[BLK_W-1-BYTE_W*DST -: BYTE_W] = subst[BLK_W-1-BYTE_W*SRC -: BYTE_W];
    end

    byte_t a0, a1, a2, a3;
    assign a0 = shifted[BLK_W-1-BYTE_W*(NROW*c+0) -: BYTE_W];
    assign a1 = shifted[BLK_W-1-BYTE_W*(NROW*c+1) -: BYTE_W];
    assign a2 = shifted[BLK_W-1-BYTE_W*(NROW*c+2) -: BYTE_W];
    assign a3 = shifted[BLK_W-1-BYTE_W*(NROW*c+3) -: BYTE_W];

    assign mixed[BLK_W-1-BYTE_W*(NROW*c+0) -: BYTE_W] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mixed[BLK_W-1-BYTE_W*(NROW*c+1) -: BYTE_W] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mixed[BLK_W-1-BYTE_W*(NROW*c+2) -: BYTE_W] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mixed[BLK_W-1-BYTE_W*(NROW*c+3) -: BYTE_W] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  assign state_o = last_i ? shifted : mixed;
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
  import aes_ip_pkg::*;
(
  input  logic [BLK_W-1:0] key_i,
  input  byte_t            rcon_i,
  output logic [BLK_W-1:0] key_o
);
  logic [WORD_W-1:0] w [NCOL];
  logic [WORD_W-1:0] n [NCOL];
  logic [WORD_W-1:0] rot_w, sub_w, mix_w;

  for (genvar j = 0; j < NCOL; j++) begin : g_split
    assign w[j] = key_i[BLK_W-1-WORD_W*j -: WORD_W];
    assign key_o[BLK_W-1-WORD_W*j -: WORD_W] = n[j];
  end

  assign rot_w = {w[NCOL-1][WORD_W-BYTE_W-1:0], w[NCOL-1][WORD_W-1 -: BYTE_W]};

  aes_sbox_lane #(.LANES(NROW)) u_sub (
    .din  (rot_w),
    .dout (sub_w)
  );

  assign mix_w = sub_w ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};
  assign n[0]  = w[0] ^ mix_w;

  for (genvar j = 1; j < NCOL; j++) begin : g_chain
    assign n[j] = w[j] ^ n[j-1];
  end
endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
  import aes_ip_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_key,
  input  logic [BLK_W-1:0] in_block,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_block
);
  logic             busy;
  logic [RND_W-1:0] rnd;
  logic [BLK_W-1:0] state_q, rkey_q;
  byte_t            rcon_q;
  logic             strobe_q;
  logic [BLK_W-1:0] xform, next_key;
  logic             take, last_rnd;

  assign take     = in_valid && !busy;
  assign last_rnd = (rnd == RND_W'(NUM_ROUNDS));

  aes_round_xform u_round (
    .state_i (state_q),
    .last_i  (last_rnd),
    .state_o (xform)
  );

  aes_key_step u_key (
    .key_i  (rkey_q),
    .rcon_i (rcon_q),
    .key_o  (next_key)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rnd      <= '0;
      state_q  <= '0;
      rkey_q   <= '0;
      rcon_q   <= RCON_FIRST;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (take) begin
        busy    <= 1'b1;
        rnd     <= RND_W'(1);
        state_q <= in_block ^ in_key;
        rkey_q  <= in_key;
        rcon_q  <= RCON_FIRST;
      end else if (busy) begin
        state_q <= xform ^ next_key;
        rkey_q  <= next_key;
        rcon_q  <= xtime(rcon_q);
        if (last_rnd) begin
          busy     <= 1'b0;
          rnd      <= '0;
          strobe_q <= 1'b1;
        end else begin
          rnd <= rnd + RND_W'(1);
        end
      end
    end
  end

  assign in_ready  = !busy;
  assign out_valid = strobe_q;
  assign out_block = state_q;

  // latency window counter used only by the checks below
  int lat_cnt;
  always_ff @(posedge clk) begin
    if (rst)                                   lat_cnt <= 0;
    else if (in_valid && in_ready)             lat_cnt <= 1;
    else if (lat_cnt == LATENCY)               lat_cnt <= 0;
    else if (lat_cnt != 0)                     lat_cnt <= lat_cnt + 1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid));

  a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  a_r3_strobe_at_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (lat_cnt == LATENCY));

  a_r3_latency_gives_strobe: assert property (@(posedge clk) disable iff (rst)
    (lat_cnt == LATENCY) |-> out_valid);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r5_busy_advances: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !last_rnd) |=> (rnd == $past(rnd) + RND_W'(1)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(out_block));
endmodule

// File: tb/aes128_iter_core_tb_top.sv
`timescale 1ns/1ps
module aes128_iter_core_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_key = '0;
  logic [127:0] in_block = '0;
  logic         in_ready, out_valid;
  logic [127:0] out_block;

  always #10 clk = ~clk;

  aes128_iter_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_block(in_block), .out_valid(out_valid), .out_block(out_block)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic started = 1'b0;
  logic [7:0] sb [256];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  // S-box via log/antilog tables over generator 3
  task automatic build_sbox();
    int lg [256];
    logic [7:0] al [256];
    logic [7:0] e, inv;
    e = 8'h01;
    for (int i = 0; i < 255; i++) begin
      al[i] = e;
      lg[e] = i;
      e = e ^ xt(e);
    end
    for (int x = 0; x < 256; x++) begin
      inv = (x == 0) ? 8'h00 : al[(255 - lg[x]) % 255];
      sb[x] = inv ^ rl(inv, 1) ^ rl(inv, 2) ^ rl(inv, 3) ^ rl(inv, 4) ^ 8'h63;
    end
  endtask

  function automatic logic [127:0] aes_ref(input logic [127:0] k, input logic [127:0] p);
    logic [7:0] st [16];
    logic [7:0] rk [16];
    logic [7:0] tp [16];
    logic [7:0] t [4];
    logic [7:0] a0, a1, a2, a3, rc;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      rk[i] = k[127-8*i -: 8];
      st[i] = p[127-8*i -: 8] ^ rk[i];
    end
    rc = 8'h01;
    for (int rn = 1; rn <= 10; rn++) begin
      for (int i = 0; i < 16; i++) st[i] = sb[st[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) tp[4*c+r] = st[4*((c+r)%4)+r];
      if (rn < 10) begin
        for (int c = 0; c < 4; c++) begin
          a0 = tp[4*c]; a1 = tp[4*c+1]; a2 = tp[4*c+2]; a3 = tp[4*c+3];
          tp[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          tp[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          tp[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          tp[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end
      end
      t[0] = sb[rk[13]] ^ rc; t[1] = sb[rk[14]]; t[2] = sb[rk[15]]; t[3] = sb[rk[12]];
      for (int j = 0; j < 4; j++) rk[j] = rk[j] ^ t[j];
      for (int j = 4; j < 16; j++) rk[j] = rk[j] ^ rk[j-4];
      rc = xt(rc);
      for (int i = 0; i < 16; i++) st[i] = tp[i] ^ rk[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = st[i];
    return res;
  endfunction

  // cycle-level reference model
  int m_cnt = 0;
  logic m_valid = 1'b0;
  logic m_have = 1'b0;
  logic [127:0] m_out = '0;
  logic [127:0] m_q [$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_valid = 1'b0; m_have = 1'b0; m_q.delete();
    end else begin
      logic idle;
      idle = (m_cnt == 0);
      m_valid = 1'b0;
      if (!idle) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_valid = 1'b1;
          m_out = m_q.pop_front();
          m_have = 1'b1;
        end
      end
      if (idle && in_valid) begin
        m_cnt = 10;
        m_q.push_back(aes_ref(in_key, in_block));
      end
    end
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      chk(in_ready == (m_cnt == 0), "R2 in_ready vs model", 128'(in_ready), 128'(m_cnt == 0));
      chk(out_valid == m_valid, "R3 R4 out_valid timing", 128'(out_valid), 128'(m_valid));
      if (m_valid)
        chk(out_block == m_out, "R7 ciphertext vs model", out_block, m_out);
      else if (m_cnt == 0 && m_have)
        chk(out_block == m_out, "R9 idle hold", out_block, m_out);
    end
  end

  task automatic send(input logic [127:0] k, input logic [127:0] p);
    @(negedge clk);
    in_key = k; in_block = p; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!out_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    logic [127:0] k, p, ex;
    build_sbox();
    chk(sb[8'h95] == 8'h2a, "R8 model sbox 95", 128'(sb[8'h95]), 128'h2a);

    repeat (3) @(negedge clk);
    chk(in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 2'b10);
    rst = 1'b0;
    started = 1'b1;

    // R6 known answer and R3 latency
    send(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff);
    wait_valid(n);
    chk(n == 10, "R3 latency negedges after accept", 128'(n), 128'd10);
    chk(out_block == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R6 known answer", out_block,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    @(negedge clk);
    chk(!out_valid, "R4 strobe one cycle", 128'(out_valid), 128'd0);
    repeat (4) @(negedge clk);
    chk(out_block == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R9 held while idle", out_block,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);

    // R8 all-zero vector
    send('0, '0);
    wait_valid(n);
    chk(out_block == 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R8 zero vector", out_block,
        128'h66e94bd4ef8a2c3b884cfa59ca342b2e);

    // R5 and R7 random blocks, with input noise while busy
    for (int v = 0; v < 20; v++) begin
      k = {$urandom, $urandom, $urandom, $urandom};
      p = {$urandom, $urandom, $urandom, $urandom};
      ex = aes_ref(k, p);
      send(k, p);
      if (v % 2 == 0) begin
        for (int j = 0; j < 5; j++) begin
          in_valid = 1'b1;
          in_key = {$urandom, $urandom, $urandom, $urandom};
          in_block = ~in_key;
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      wait_valid(n);
      chk(out_block == ex, "R5 R7 random block result", out_block, ex);
      repeat (v % 3) @(negedge clk);
    end

    // R10 back-to-back acceptance in the strobe cycle
    k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    p = 128'h3243f6a8885a308d313198a2e0370734;
    @(negedge clk);
    in_key = k; in_block = p; in_valid = 1'b1;
    @(negedge clk);
    wait_valid(n);
    chk(in_ready == 1'b1, "R10 ready in strobe cycle", 128'(in_ready), 128'd1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R10 accepted in strobe cycle", 128'(in_ready), 128'd0);
    in_valid = 1'b0;
    wait_valid(n);
    chk(out_block == aes_ref(k, p), "R10 second block result", out_block, aes_ref(k, p));

    // R1 reset during a run
    send(k, ~p);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R1 reset mid-run", {in_ready, out_valid}, 2'b10);
    rst = 1'b0;
    n = 0;
    for (int j = 0; j < 15; j++) begin
      @(negedge clk);
      if (out_valid) n++;
    end
    chk(n == 0, "R1 no strobe after abort", 128'(n), 128'd0);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule